// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This block serves one work queue. It keeps a count of finished instructions that asked to be reported by interrupt. It drives one interrupt request line. The line rises as soon as either of two conditions holds: enough completions have built up, or enough time has passed since the count last became nonzero or was last restarted. The time setting is given in units of 1024 clock cycles. Grouping completions like this lets software handle many results per interrupt without leaving any result waiting for a long time.

Software answers an interrupt by writing an acknowledge amount. That amount is taken off the count and the timer starts again from zero. The trigger is then worked out again straight away from the remaining count. So a completion that arrives while software is acknowledging causes a new interrupt and is never lost. A diagnostic port can load the count directly. The interrupt enable is a sticky bit that can only be set. While it is clear, counting and timing still run, but the line stays low.

Top module: `intr_coalesce_unit`

## Requirements
- R1: A completion pulse (`cmpl_vld`=1) with its notify flag (`cmpl_notify`=1) adds one to `done_cnt` at the next clock edge. A pulse whose flag is 0 leaves the count unchanged.
- R2: While `done_cnt` is zero, `irq` is 0 and the internal timer stays at zero, whatever `time_wait` is set to.
- R3: With the enable set and a nonzero count, `irq` is 1 whenever `done_cnt` >= `num_wait`. A `num_wait` of 0 acts as 1.
- R4: With the enable set and a nonzero count, `irq` is 1 once the timer reaches `time_wait`*1024. The timer counts one per cycle from the edge at which the count became nonzero or was last restarted. A `time_wait` of 0 turns the time condition off.
- R5: An acknowledge write (`ack_we`=1) subtracts `ack_amt` from the count. If `ack_amt` is larger than the count, the count clamps to zero. The write also clears the timer, including when `ack_amt` is 0.
- R6: The trigger is evaluated again in the same cycle the decremented count appears. If the remaining count still meets `num_wait`, `irq` stays or comes back at 1 with no delay.
- R7: A diagnostic write (`cnt_we`=1) loads `cnt_wdata` into the count. It wins over a completion or an acknowledge in the same cycle, and it clears the timer.
- R8: A counted completion and an acknowledge in the same cycle both take effect: the new count is count + 1 - `ack_amt`, clamped at zero.
- R9: `ena_set_we`=1 with `ena_set_bit`=1 sets the enable, which `ena_rd` reports. Writing 0 has no effect. Only reset clears the enable. While it is clear, `irq` is 0 but counting and timing go on.
- R10: The count saturates at 2^`CNT_W`-1 rather than wrapping. The timer also saturates at its maximum value.
- R11: After reset, `done_cnt`=0, `irq`=0 and `ena_rd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_vld | input | 1 | An instruction finished this cycle |
| cmpl_notify | input | 1 | The finished instruction asked for an interrupt |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_amt | input | CNT_W (20) | Amount to subtract from the count |
| cnt_we | input | 1 | Diagnostic count-load strobe |
| cnt_wdata | input | CNT_W (20) | Value loaded by the diagnostic write |
| time_wait | input | TWAIT_W (16) | Time threshold in units of 2^TIME_SHIFT cycles; 0 turns it off |
| num_wait | input | CNT_W (20) | Count threshold; 0 acts as 1 |
| ena_set_we | input | 1 | Enable write strobe |
| ena_set_bit | input | 1 | Enable write data; only 1 has an effect |
| irq | output | 1 | Interrupt request |
| ena_rd | output | 1 | Current enable state |
| done_cnt | output | CNT_W (20) | Current completion count |

## Verification
A counted completion can land in the same cycle as an acknowledge or a diagnostic load. The bench drives both strobes in one cycle, with the count just at the threshold and with an acknowledge larger than the count. A cycle-accurate reference model written from the requirements checks the next count (count + 1 - ack clamped at zero, or the loaded value) and whether the interrupt stays high at once. The same model follows the hidden timer, so a restart caused by either write is judged by when the time-based interrupt rises across runs of more than a thousand cycles.

// File: rtl/coal_pkg.sv
package coal_pkg;

   // Default scaling of the time threshold: one unit of time_wait is 2^10 cycles.
   localparam int unsigned COAL_TIME_SHIFT_DEF = 10;

   // Timer step chosen for the coming clock edge.
   typedef enum logic [1:0] {
      TMR_CLEAR = 2'd0,
      TMR_RUN   = 2'd1,
      TMR_HOLD  = 2'd2
   } tmr_act_e;

endpackage

// File: rtl/coal_count.sv
module coal_count #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec_we,
   input  logic [CNT_W-1:0] dec_amt,
   input  logic             load_we,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             cnt_zero
);

   localparam int unsigned EXT_W = CNT_W + 1;
   localparam logic [EXT_W-1:0] CNT_TOP = {1'b0, {CNT_W{1'b1}}};

   logic [EXT_W-1:0] sum_ext;
   logic [EXT_W-1:0] after_dec;
   logic [CNT_W-1:0] cnt_d;

   // Increment and decrement are done one extra bit wide so that a
   // same-cycle add/subtract cannot wrap before it is clamped.
   always_comb begin
      sum_ext = {1'b0, cnt_q} + {{CNT_W{1'b0}}, inc};
      if (dec_we) begin
         if ({1'b0, dec_amt} >= sum_ext) begin
            after_dec = '0;
         end else begin
            after_dec = sum_ext - {1'b0, dec_amt};
         end
      end else begin
         after_dec = sum_ext;
      end
      if (load_we) begin
         cnt_d = load_val;
      end else if (after_dec > CNT_TOP) begin
         cnt_d = CNT_TOP[CNT_W-1:0];
      end else begin
         cnt_d = after_dec[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
   parameter int unsigned TMR_W = 26
) (
   input  logic                clk,
   input  logic                rst_n,
   input  coal_pkg::tmr_act_e  act,
   output logic [TMR_W-1:0]    tmr_q,
   output logic                tmr_full
);

   import coal_pkg::*;

   assign tmr_full = (tmr_q == {TMR_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else begin
         unique case (act)
            TMR_CLEAR: tmr_q <= '0;
            TMR_RUN:   tmr_q <= tmr_q + 1'b1;
            default:   tmr_q <= tmr_q;
         endcase
      end
   end

endmodule

// File: rtl/coal_enable.sv
module coal_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic set_we,
   input  logic set_bit,
   output logic ena_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q <= 1'b0;
      end else if (set_we && set_bit) begin
         ena_q <= 1'b1;
      end
   end

endmodule

// File: rtl/coal_trigger.sv
module coal_trigger #(
   parameter int unsigned CNT_W      = 20,
   parameter int unsigned TWAIT_W    = 16,
   parameter int unsigned TIME_SHIFT = 10,
   localparam int unsigned TMR_W     = TWAIT_W + TIME_SHIFT
) (
   input  logic [CNT_W-1:0]   cnt,
   input  logic               cnt_zero,
   input  logic [TMR_W-1:0]   tmr,
   input  logic [TWAIT_W-1:0] time_wait,
   input  logic [CNT_W-1:0]   num_wait,
   input  logic               ena,
   output logic               irq
);

   logic [TMR_W-1:0] tmr_limit;
   logic [CNT_W-1:0] num_eff;
   logic             hit_num;
   logic             hit_time;

   // Scale the time threshold into timer ticks.
   generate
      if (TIME_SHIFT == 0) begin : g_unscaled
         assign tmr_limit = time_wait;
      end else begin : g_scaled
         assign tmr_limit = {time_wait, {TIME_SHIFT{1'b0}}};
      end
   endgenerate

   assign num_eff  = (num_wait == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : num_wait;
   assign hit_num  = (cnt >= num_eff);
   assign hit_time = (time_wait != '0) && (tmr >= tmr_limit);
   assign irq      = ena && !cnt_zero && (hit_num || hit_time);

endmodule

// File: rtl/intr_coalesce_unit.sv
module intr_coalesce_unit #(
   parameter int unsigned CNT_W      = 20,
   parameter int unsigned TWAIT_W    = 16,
   parameter int unsigned TIME_SHIFT = coal_pkg::COAL_TIME_SHIFT_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmpl_vld,
   input  logic               cmpl_notify,
   input  logic               ack_we,
   input  logic [CNT_W-1:0]   ack_amt,
   input  logic               cnt_we,
   input  logic [CNT_W-1:0]   cnt_wdata,
   input  logic [TWAIT_W-1:0] time_wait,
   input  logic [CNT_W-1:0]   num_wait,
   input  logic               ena_set_we,
   input  logic               ena_set_bit,
   output logic               irq,
   output logic               ena_rd,
   output logic [CNT_W-1:0]   done_cnt
);

   import coal_pkg::*;

   localparam int unsigned TMR_W = TWAIT_W + TIME_SHIFT;

   // Elaboration-time checks on the parameters.
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("intr_coalesce_unit: CNT_W must lie in 2..32");
      end
      if (TWAIT_W < 1 || TWAIT_W > 24) begin : g_bad_twait_w
         $error("intr_coalesce_unit: TWAIT_W must lie in 1..24");
      end
      if (TIME_SHIFT > 16) begin : g_bad_shift
         $error("intr_coalesce_unit: TIME_SHIFT must not exceed 16");
      end
   endgenerate

   logic             cnt_inc;
   logic             cnt_zero;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_full;
   tmr_act_e         tmr_act;

   assign cnt_inc = cmpl_vld && cmpl_notify;

   coal_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (cnt_inc),
      .dec_we   (ack_we),
      .dec_amt  (ack_amt),
      .load_we  (cnt_we),
      .load_val (cnt_wdata),
      .cnt_q    (done_cnt),
      .cnt_zero (cnt_zero)
   );

   // The timer is cleared by either software write or while nothing is
   // pending, runs while work is pending, and stops at its top value.
   always_comb begin
      if (ack_we || cnt_we || cnt_zero) begin
         tmr_act = TMR_CLEAR;
      end else if (tmr_full) begin
         tmr_act = TMR_HOLD;
      end else begin
         tmr_act = TMR_RUN;
      end
   end

   coal_timer #(.TMR_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (tmr_act),
      .tmr_q    (tmr_val),
      .tmr_full (tmr_full)
   );

   coal_enable u_enable (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (ena_set_we),
      .set_bit (ena_set_bit),
      .ena_q   (ena_rd)
   );

   coal_trigger #(
      .CNT_W      (CNT_W),
      .TWAIT_W    (TWAIT_W),
      .TIME_SHIFT (TIME_SHIFT)
   ) u_trigger (
      .cnt       (done_cnt),
      .cnt_zero  (cnt_zero),
      .tmr       (tmr_val),
      .time_wait (time_wait),
      .num_wait  (num_wait),
      .ena       (ena_rd),
      .irq       (irq)
   );

endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
   parameter int unsigned CNT_W = 20,
   parameter int unsigned TWAIT_W = 16,
   parameter int unsigned TMR_W = 26
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmpl_vld,
   input logic               cmpl_notify,
   input logic               ack_we,
   input logic [CNT_W-1:0]   ack_amt,
   input logic               cnt_we,
   input logic [CNT_W-1:0]   cnt_wdata,
   input logic [TWAIT_W-1:0] time_wait,
   input logic [CNT_W-1:0]   num_wait,
   input logic               irq,
   input logic               ena_rd,
   input logic [CNT_W-1:0]   done_cnt,
   input logic [TMR_W-1:0]   tmr
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] num_eff;
   assign num_eff = (num_wait == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : num_wait;

   // R1: a counted completion alone moves the count up by one
   p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_vld && cmpl_notify && !ack_we && !cnt_we && done_cnt != CNT_TOP)
      |=> (done_cnt == $past(done_cnt) + 1'b1));

   // R2: nothing pending means no request
   p_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_cnt == '0) |-> !irq);

   // R2: the timer is at zero one edge after an empty count
   p_tmr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_cnt == '0) |=> (tmr == '0));

   // R3: the count threshold forces the request when enabled
   p_num_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_rd && done_cnt != '0 && done_cnt >= num_eff) |-> irq);

   // R4: with time coalescing off only the count threshold can raise it
   p_notime_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (time_wait == '0 && done_cnt < num_eff) |-> !irq);

   // R5: an acknowledge clears the timer
   p_ack_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> (tmr == '0));

   // R5: an oversized acknowledge clamps at zero
   p_ack_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && !cnt_we && !(cmpl_vld && cmpl_notify) && ack_amt >= done_cnt)
      |=> (done_cnt == '0));

   // R7: a diagnostic load wins and restarts the timer
   p_diag_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (done_cnt == $past(cnt_wdata) && tmr == '0));

   // R9: the enable never falls once set
   p_ena_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ena_rd |=> ena_rd);

   // R9: no request while disabled
   p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ena_rd |-> !irq);

   // R10: the count stays at its top on a further completion
   p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_cnt == CNT_TOP && cmpl_vld && cmpl_notify && !ack_we && !cnt_we)
      |=> (done_cnt == CNT_TOP));

endmodule

bind intr_coalesce_unit coal_chk #(
   .CNT_W   (CNT_W),
   .TWAIT_W (TWAIT_W),
   .TMR_W   (TWAIT_W + TIME_SHIFT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmpl_vld    (cmpl_vld),
   .cmpl_notify (cmpl_notify),
   .ack_we      (ack_we),
   .ack_amt     (ack_amt),
   .cnt_we      (cnt_we),
   .cnt_wdata   (cnt_wdata),
   .time_wait   (time_wait),
   .num_wait    (num_wait),
   .irq         (irq),
   .ena_rd      (ena_rd),
   .done_cnt    (done_cnt),
   .tmr         (tmr_val)
);

// File: tb/sim_intr_coalesce_unit.sv
`timescale 1ns/1ps
module sim_intr_coalesce_unit;

   localparam int CW = 20;
   localparam int TW = 16;
   localparam int SH = 10;
   localparam longint CMAX = (64'd1 << CW) - 1;
   localparam longint TMAX = (64'd1 << (TW + SH)) - 1;

   logic          clk;
   logic          rst_n;
   logic          cmpl_vld, cmpl_notify;
   logic          ack_we;
   logic [CW-1:0] ack_amt;
   logic          cnt_we;
   logic [CW-1:0] cnt_wdata;
   logic [TW-1:0] time_wait;
   logic [CW-1:0] num_wait;
   logic          ena_set_we, ena_set_bit;
   logic          irq, ena_rd;
   logic [CW-1:0] done_cnt;

   intr_coalesce_unit #(.CNT_W(CW), .TWAIT_W(TW), .TIME_SHIFT(SH)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmpl_vld(cmpl_vld), .cmpl_notify(cmpl_notify),
      .ack_we(ack_we), .ack_amt(ack_amt),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .time_wait(time_wait), .num_wait(num_wait),
      .ena_set_we(ena_set_we), .ena_set_bit(ena_set_bit),
      .irq(irq), .ena_rd(ena_rd), .done_cnt(done_cnt)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Scoreboard queues: one entry per clock edge driven by the driver.
   longint q_cnt[$];
   bit     q_irq[$];
   bit     q_ena[$];
   string  q_tag[$];

   // Reference state built from the requirements.
   longint m_cnt = 0;
   longint m_tmr = 0;
   bit     m_ena = 0;
   longint g_tw = 0;
   longint g_nw = 0;

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Driver: applies one cycle of stimulus and pushes the expected result.
   task automatic step(input bit cv, input bit cn, input bit aw, input longint aa,
                       input bit lw, input longint lv, input bit ew, input bit ed,
                       input string tag);
      longint nc, nt, s, neff;
      bit ne, ei;
      @(negedge clk);
      cmpl_vld = cv; cmpl_notify = cn;
      ack_we = aw; ack_amt = CW'(aa);
      cnt_we = lw; cnt_wdata = CW'(lv);
      ena_set_we = ew; ena_set_bit = ed;
      time_wait = TW'(g_tw); num_wait = CW'(g_nw);
      if (lw) begin
         nc = lv;
      end else begin
         s = m_cnt + ((cv && cn) ? 1 : 0);
         if (aw) s = (aa >= s) ? 0 : s - aa;
         if (s > CMAX) s = CMAX;
         nc = s;
      end
      if (aw || lw || m_cnt == 0) nt = 0;
      else nt = (m_tmr < TMAX) ? m_tmr + 1 : m_tmr;
      ne = m_ena | (ew & ed);
      neff = (g_nw == 0) ? 1 : g_nw;
      ei = ne && (nc != 0) && ((nc >= neff) || (g_tw != 0 && nt >= (g_tw << SH)));
      m_cnt = nc; m_tmr = nt; m_ena = ne;
      q_cnt.push_back(nc); q_irq.push_back(ei); q_ena.push_back(ne); q_tag.push_back(tag);
      @(posedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic comp(input bit flag, input string tag);
      step(1, flag, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic ack(input longint n, input string tag);
      step(0, 0, 1, n, 0, 0, 0, 0, tag);
   endtask

   // Monitor: compares outputs just after each edge against the queue head.
   always @(posedge clk) begin
      longint ec;
      bit ei, ee;
      string tg;
      #1;
      if (q_cnt.size() != 0) begin
         ec = q_cnt.pop_front();
         ei = q_irq.pop_front();
         ee = q_ena.pop_front();
         tg = q_tag.pop_front();
         chk(tg, "done_cnt", longint'(done_cnt), ec);
         chk(tg, "irq", longint'(irq), longint'(ei));
         chk(tg, "ena_rd", longint'(ena_rd), longint'(ee));
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cmpl_vld = 0; cmpl_notify = 0; ack_we = 0; ack_amt = '0;
      cnt_we = 0; cnt_wdata = '0; time_wait = '0; num_wait = '0;
      ena_set_we = 0; ena_set_bit = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk("R11", "done_cnt", longint'(done_cnt), 0);
      chk("R11", "irq", longint'(irq), 0);
      chk("R11", "ena_rd", longint'(ena_rd), 0);

      // R1: flagged completions count, unflagged ones do not
      g_nw = 3; g_tw = 0;
      comp(1, "R1"); comp(1, "R1"); comp(0, "R1");
      // R9: counting goes on while disabled, request held low
      comp(1, "R9");
      step(0, 0, 0, 0, 0, 0, 1, 0, "R9");       // writing 0 has no effect
      step(0, 0, 0, 0, 0, 0, 1, 1, "R9");       // set enable: count 3 meets 3
      idle(2, "R3");
      // R5: acknowledge subtracts, then clamps
      ack(1, "R5"); ack(5, "R5");
      // R3: zero threshold acts as one
      g_nw = 0;
      comp(1, "R3"); ack(1, "R5");
      // R6: remaining count still over threshold keeps the request up
      g_nw = 2;
      comp(1, "R6"); comp(1, "R6"); comp(1, "R6");
      ack(1, "R6");
      // R8: completion and acknowledge together
      step(1, 1, 1, 2, 0, 0, 0, 0, "R8");
      step(1, 1, 1, 1, 0, 0, 0, 0, "R8");
      step(1, 1, 1, 9, 0, 0, 0, 0, "R8");
      comp(1, "R8");
      // R4: time threshold of one unit
      g_nw = 100; g_tw = 1;
      ack(0, "R4");
      idle(1030, "R4");
      g_tw = 0;
      idle(3, "R4");
      g_tw = 2;
      idle(2100, "R4");
      ack(0, "R5");
      idle(2, "R5");
      // R2: timer held while nothing pending
      g_tw = 1;
      ack(10, "R2");
      idle(1100, "R2");
      comp(1, "R4");
      idle(1030, "R4");
      // R7: diagnostic load wins and restarts the timer
      step(1, 1, 0, 0, 1, 7, 0, 0, "R7");
      idle(1000, "R7");
      step(0, 0, 0, 0, 1, 7, 0, 0, "R7");
      idle(1000, "R7");
      idle(30, "R7");
      step(1, 1, 1, 2, 1, 4, 0, 0, "R7");
      // R10: count saturation
      g_nw = 5;
      step(0, 0, 0, 0, 1, CMAX, 0, 0, "R10");
      comp(1, "R10");
      comp(1, "R10");
      step(0, 0, 0, 0, 0, 0, 1, 0, "R9");       // enable stays set
      ack(CMAX, "R5");
      idle(3, "R2");

      @(posedge clk);
      #2;
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule